// File: doc/BRIEF.md
# Peak Energy Window Capture

This block acts as a small logic analyzer over one instrument sweep. While a sweep runs, each arriving count is written into an on-chip buffer addressed by its energy step, deflector step and anode, and a running search remembers the bin with the largest count among the bins that satisfy the configured energy bounds, deflector bounds and anode mask. When the sweep-done strobe arrives, the block turns the peak into a rectangular window of energy and deflector steps. It then streams out every stored count inside that window, one bin per cycle at most, and exports the indices of the peak it found.

The window spans the configured energy offset on both sides of the peak energy and the deflector offset on both sides of the peak deflector. Near a bound the window slides inward rather than shrinking. After the readout, every bin of the buffer is marked empty, so the next sweep starts from zero. The buffer is sized by parameters, smaller than a full instrument grid. Index ports keep their full widths, and any bin beyond the buffer dimensions is dropped.

Top module: `peak_window_capture`

## Requirements
- R1: Each word read out carries the count last written to that bin during the sweep; a bin not written during the sweep reads as 0.
- R2: A bin qualifies when its energy lies in [energy lower, min(energy upper, NE-1)], its deflector lies in [deflector lower, min(deflector upper, ND-1)] and its bit in the anode mask (bit i = anode i) is 1. The peak is the qualifying bin with the largest count. On a tie, the bin that arrived first wins.
- R3: When it fits inside the effective bounds, the window covers energies peakE-eOffset..peakE+eOffset and deflectors peakD-dOffset..peakD+dOffset, symmetric about the peak.
- R4: A window that would cross a bound is shifted inward and keeps its size 2*offset+1. If 2*offset is at least the effective upper bound minus the lower bound, the window covers the whole effective range.
- R5: Readout words come in ascending energy, then deflector, then anode order. Only anodes whose mask bit is 1 appear, and `outLast` is 1 on exactly the final word.
- R6: After each readout, `peakEnergy`, `peakDefl` and `peakAnode` hold the indices of the peak of that sweep. These outputs change only in the cycle after a sweep is closed.
- R7: If no bin qualified during a sweep, no word is read out and the exported peak indices keep their previous values.
- R8: While `busy` is 1, `binValid` and `sweepDone` are ignored. A bin presented in the same cycle as `sweepDone` still belongs to the closing sweep.
- R9: After reset, `busy`, `outValid` and `outLast` are 0 and the exported peak indices are 0.
- R10: A bin whose energy is at least NE, whose deflector is at least ND or whose anode is at least NA is neither stored nor considered for the peak.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| binValid | input | 1 | A count for one bin is presented |
| binEnergy | input | 7 | Energy step of the bin |
| binDefl | input | 5 | Deflector step of the bin |
| binAnode | input | 5 | Anode of the bin |
| binCount | input | 8 | Count value of the bin |
| sweepDone | input | 1 | Closes the current sweep |
| cfgELower | input | 7 | Lowest energy step in the search and window |
| cfgEUpper | input | 7 | Highest energy step in the search and window |
| cfgDLower | input | 5 | Lowest deflector step in the search and window |
| cfgDUpper | input | 5 | Highest deflector step in the search and window |
| cfgMask | input | 24 | Anode enable, bit i for anode i |
| cfgEOffset | input | 6 | Energy half-width of the window |
| cfgDOffset | input | 4 | Deflector half-width of the window |
| busy | output | 1 | Sweep closing, readout or clearing in progress |
| outValid | output | 1 | A readout word is present |
| outLast | output | 1 | Final word of the readout |
| outCount | output | 8 | Count of the bin read out |
| outEnergy | output | 7 | Energy step of the bin read out |
| outDefl | output | 5 | Deflector step of the bin read out |
| outAnode | output | 5 | Anode of the bin read out |
| peakEnergy | output | 7 | Energy step of the most recent peak |
| peakDefl | output | 5 | Deflector step of the most recent peak |
| peakAnode | output | 5 | Anode of the most recent peak |

## Verification
If the running search holds a wrong peak, the error shows two cycles after `sweepDone`. The exported indices are wrong, and the first readout word then starts at the wrong energy or deflector step. If a window edge or the clamp is computed wrongly, the stream has the wrong length and the wrong last word. If the empty marks are not cleared, stale counts from the previous sweep appear in the next readout, in the first word that covers an unwritten bin. If the scan counters are wrong, the order of the words breaks, or a word appears for a masked anode, in the cycle the counter goes astray.

// File: rtl/pwc_pkg.sv
package pwc_pkg;

  typedef enum logic [1:0] {
    ST_COLLECT,
    ST_CALC,
    ST_READ,
    ST_CLEAR
  } pwcState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic takeBins;
    logic latchWindow;
    logic readEn;
    logic clearStore;
  } pwcCtl_t;

  // status from datapath to control
  typedef struct packed {
    logic found;
    logic atEnd;
  } pwcStat_t;

endpackage

// File: rtl/pwc_clamp.sv
module pwc_clamp #(
  parameter int IW = 7,
  parameter int OW = 6
) (
  input  logic [IW-1:0] peak,
  input  logic [OW-1:0] off,
  input  logic [IW-1:0] lo,
  input  logic [IW-1:0] hi,
  output logic [IW-1:0] first,
  output logic [IW-1:0] last
);
  localparam int XW = (IW > OW ? IW : OW) + 2;

  logic [XW-1:0] p, o, l, h, twoO, span, f, t;

  always_comb begin
    p    = XW'(peak);
    o    = XW'(off);
    l    = XW'(lo);
    h    = XW'(hi);
    twoO = o << 1;
    span = h - l;
    if (twoO >= span) begin
      f = l;
      t = h;
    end else if (p < l + o) begin
      f = l;
      t = l + twoO;
    end else if (p + o > h) begin
      f = h - twoO;
      t = h;
    end else begin
      f = p - o;
      t = p + o;
    end
    first = f[IW-1:0];
    last  = t[IW-1:0];
  end
endmodule

// File: rtl/pwc_ctrl.sv
module pwc_ctrl
  import pwc_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     sweepDone,
  input  pwcStat_t stat,
  output pwcCtl_t  ctl,
  output logic     busy
);
  pwcState_t state, stateNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_COLLECT;
    else       state <= stateNext;
  end

  always_comb begin
    ctl       = '0;
    stateNext = state;
    unique case (state)
      ST_COLLECT: begin
        ctl.takeBins = 1'b1;
        if (sweepDone) stateNext = ST_CALC;
      end
      ST_CALC: begin
        ctl.latchWindow = 1'b1;
        stateNext = stat.found ? ST_READ : ST_CLEAR;
      end
      ST_READ: begin
        ctl.readEn = 1'b1;
        if (stat.atEnd) stateNext = ST_CLEAR;
      end
      ST_CLEAR: begin
        ctl.clearStore = 1'b1;
        stateNext = ST_COLLECT;
      end
      default: stateNext = ST_COLLECT;
    endcase
  end

  assign busy = (state != ST_COLLECT);
endmodule

// File: rtl/pwc_datapath.sv
module pwc_datapath
  import pwc_pkg::*;
#(
  parameter int NE     = 8,
  parameter int ND     = 4,
  parameter int NA     = 24,
  parameter int CW     = 8,
  parameter int E_W    = 7,
  parameter int D_W    = 5,
  parameter int A_W    = 5,
  parameter int EOFF_W = 6,
  parameter int DOFF_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  pwcCtl_t           ctl,
  output pwcStat_t          stat,
  input  logic              binValid,
  input  logic [E_W-1:0]    binEnergy,
  input  logic [D_W-1:0]    binDefl,
  input  logic [A_W-1:0]    binAnode,
  input  logic [CW-1:0]     binCount,
  input  logic [E_W-1:0]    cfgELower,
  input  logic [E_W-1:0]    cfgEUpper,
  input  logic [D_W-1:0]    cfgDLower,
  input  logic [D_W-1:0]    cfgDUpper,
  input  logic [NA-1:0]     cfgMask,
  input  logic [EOFF_W-1:0] cfgEOffset,
  input  logic [DOFF_W-1:0] cfgDOffset,
  output logic              outValid,
  output logic              outLast,
  output logic [CW-1:0]     outCount,
  output logic [E_W-1:0]    outEnergy,
  output logic [D_W-1:0]    outDefl,
  output logic [A_W-1:0]    outAnode,
  output logic [E_W-1:0]    peakEnergy,
  output logic [D_W-1:0]    peakDefl,
  output logic [A_W-1:0]    peakAnode
);
  localparam int DEPTH = NE * ND * NA;
  localparam int AW    = $clog2(DEPTH);

  logic [CW-1:0]    mem [DEPTH];
  logic [DEPTH-1:0] memVld;

  logic [E_W-1:0] eHiEff;
  logic [D_W-1:0] dHiEff;
  logic           inBuf, qual, wrEn, better;
  logic [AW-1:0]  wrAddr, rdAddr;

  // running search state
  logic           pkFound;
  logic [CW-1:0]  pkCount;
  logic [E_W-1:0] pkE;
  logic [D_W-1:0] pkD;
  logic [A_W-1:0] pkA;

  // window and scan state
  logic [E_W-1:0] winE0, winE1, rdE, endE;
  logic [D_W-1:0] winD0, winD1, rdD, startD, endD;
  logic [A_W-1:0] rdA, lastA, lastAC;
  logic           atEnd;

  assign eHiEff = (int'(cfgEUpper) > NE - 1) ? E_W'(NE - 1) : cfgEUpper;
  assign dHiEff = (int'(cfgDUpper) > ND - 1) ? D_W'(ND - 1) : cfgDUpper;

  always_comb begin
    inBuf  = (int'(binEnergy) < NE) && (int'(binDefl) < ND) && (int'(binAnode) < NA);
    wrEn   = ctl.takeBins && binValid && inBuf;
    wrAddr = AW'(int'(binEnergy) * ND * NA + int'(binDefl) * NA + int'(binAnode));
    qual   = inBuf && (binEnergy >= cfgELower) && (binEnergy <= eHiEff)
             && (binDefl >= cfgDLower) && (binDefl <= dHiEff)
             && cfgMask[binAnode];
    better = !pkFound || (binCount > pkCount);
    rdAddr = AW'(int'(rdE) * ND * NA + int'(rdD) * NA + int'(rdA));
  end

  // buffer storage, no reset on the data array
  always_ff @(posedge clk) begin
    if (wrEn) mem[wrAddr] <= binCount;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               memVld <= '0;
    else if (ctl.clearStore) memVld <= '0;
    else if (wrEn)           memVld[wrAddr] <= 1'b1;
  end

  // peak search: strict greater keeps the earliest of equal counts
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pkFound <= 1'b0;
      pkCount <= '0;
      pkE     <= '0;
      pkD     <= '0;
      pkA     <= '0;
    end else if (ctl.clearStore) begin
      pkFound <= 1'b0;
    end else if (wrEn && qual && better) begin
      pkFound <= 1'b1;
      pkCount <= binCount;
      pkE     <= binEnergy;
      pkD     <= binDefl;
      pkA     <= binAnode;
    end
  end

  pwc_clamp #(.IW(E_W), .OW(EOFF_W)) u_clampE (
    .peak(pkE), .off(cfgEOffset), .lo(cfgELower), .hi(eHiEff),
    .first(winE0), .last(winE1)
  );

  pwc_clamp #(.IW(D_W), .OW(DOFF_W)) u_clampD (
    .peak(pkD), .off(cfgDOffset), .lo(cfgDLower), .hi(dHiEff),
    .first(winD0), .last(winD1)
  );

  always_comb begin
    lastAC = '0;
    for (int i = 0; i < NA; i++) begin
      if (cfgMask[i]) lastAC = A_W'(i);
    end
  end

  assign atEnd = (rdE == endE) && (rdD == endD) && (rdA == lastA);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdE        <= '0;
      endE       <= '0;
      rdD        <= '0;
      startD     <= '0;
      endD       <= '0;
      rdA        <= '0;
      lastA      <= '0;
      outValid   <= 1'b0;
      outLast    <= 1'b0;
      outCount   <= '0;
      outEnergy  <= '0;
      outDefl    <= '0;
      outAnode   <= '0;
      peakEnergy <= '0;
      peakDefl   <= '0;
      peakAnode  <= '0;
    end else begin
      outValid <= 1'b0;
      outLast  <= 1'b0;
      if (ctl.latchWindow) begin
        rdE    <= winE0;
        endE   <= winE1;
        rdD    <= winD0;
        startD <= winD0;
        endD   <= winD1;
        rdA    <= '0;
        lastA  <= lastAC;
        if (pkFound) begin
          peakEnergy <= pkE;
          peakDefl   <= pkD;
          peakAnode  <= pkA;
        end
      end
      if (ctl.readEn) begin
        outValid  <= cfgMask[rdA];
        outLast   <= atEnd;
        outCount  <= memVld[rdAddr] ? mem[rdAddr] : '0;
        outEnergy <= rdE;
        outDefl   <= rdD;
        outAnode  <= rdA;
        if (rdA == lastA) begin
          rdA <= '0;
          if (rdD == endD) begin
            rdD <= startD;
            rdE <= rdE + 1'b1;
          end else begin
            rdD <= rdD + 1'b1;
          end
        end else begin
          rdA <= rdA + 1'b1;
        end
      end
    end
  end

  assign stat.found = pkFound;
  assign stat.atEnd = atEnd;
endmodule

// File: rtl/peak_window_capture.sv
module peak_window_capture
  import pwc_pkg::*;
#(
  parameter int NE     = 8,
  parameter int ND     = 4,
  parameter int NA     = 24,
  parameter int CW     = 8,
  parameter int E_W    = 7,
  parameter int D_W    = 5,
  parameter int A_W    = 5,
  parameter int EOFF_W = 6,
  parameter int DOFF_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              binValid,
  input  logic [E_W-1:0]    binEnergy,
  input  logic [D_W-1:0]    binDefl,
  input  logic [A_W-1:0]    binAnode,
  input  logic [CW-1:0]     binCount,
  input  logic              sweepDone,
  input  logic [E_W-1:0]    cfgELower,
  input  logic [E_W-1:0]    cfgEUpper,
  input  logic [D_W-1:0]    cfgDLower,
  input  logic [D_W-1:0]    cfgDUpper,
  input  logic [NA-1:0]     cfgMask,
  input  logic [EOFF_W-1:0] cfgEOffset,
  input  logic [DOFF_W-1:0] cfgDOffset,
  output logic              busy,
  output logic              outValid,
  output logic              outLast,
  output logic [CW-1:0]     outCount,
  output logic [E_W-1:0]    outEnergy,
  output logic [D_W-1:0]    outDefl,
  output logic [A_W-1:0]    outAnode,
  output logic [E_W-1:0]    peakEnergy,
  output logic [D_W-1:0]    peakDefl,
  output logic [A_W-1:0]    peakAnode
);
  pwcCtl_t  ctl;
  pwcStat_t stat;

  pwc_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .sweepDone(sweepDone),
    .stat(stat), .ctl(ctl), .busy(busy)
  );

  pwc_datapath #(
    .NE(NE), .ND(ND), .NA(NA), .CW(CW), .E_W(E_W), .D_W(D_W),
    .A_W(A_W), .EOFF_W(EOFF_W), .DOFF_W(DOFF_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .stat(stat),
    .binValid(binValid), .binEnergy(binEnergy), .binDefl(binDefl),
    .binAnode(binAnode), .binCount(binCount),
    .cfgELower(cfgELower), .cfgEUpper(cfgEUpper),
    .cfgDLower(cfgDLower), .cfgDUpper(cfgDUpper), .cfgMask(cfgMask),
    .cfgEOffset(cfgEOffset), .cfgDOffset(cfgDOffset),
    .outValid(outValid), .outLast(outLast), .outCount(outCount),
    .outEnergy(outEnergy), .outDefl(outDefl), .outAnode(outAnode),
    .peakEnergy(peakEnergy), .peakDefl(peakDefl), .peakAnode(peakAnode)
  );
endmodule

// File: rtl/pwc_checker.sv
module pwc_checker #(
  parameter int NA     = 24,
  parameter int CW     = 8,
  parameter int E_W    = 7,
  parameter int D_W    = 5,
  parameter int A_W    = 5
) (
  input logic           clk,
  input logic           rstN,
  input logic           busy,
  input logic           outValid,
  input logic           outLast,
  input logic [E_W-1:0] outEnergy,
  input logic [D_W-1:0] outDefl,
  input logic [A_W-1:0] outAnode,
  input logic [E_W-1:0] cfgELower,
  input logic [E_W-1:0] cfgEUpper,
  input logic [D_W-1:0] cfgDLower,
  input logic [D_W-1:0] cfgDUpper,
  input logic [NA-1:0]  cfgMask,
  input logic [E_W-1:0] peakEnergy,
  input logic [D_W-1:0] peakDefl,
  input logic [A_W-1:0] peakAnode
);
  // R4: every word lies within the configured bounds
  p_in_bounds_r4: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> (outEnergy >= cfgELower && outEnergy <= cfgEUpper &&
                  outDefl >= cfgDLower && outDefl <= cfgDUpper));

  // R5: only enabled anodes are read out
  p_mask_r5: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> cfgMask[outAnode]);

  // R5: the last flag marks a real word
  p_last_word_r5: assert property (@(posedge clk) disable iff (!rstN)
    outLast |-> outValid);

  // R5: back-to-back words ascend in energy, deflector, anode order
  p_order_r5: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && $past(outValid)) |->
      ({outEnergy, outDefl, outAnode} > $past({outEnergy, outDefl, outAnode})));

  // R8: no readout words while collecting
  p_quiet_idle_r8: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !outValid);

  // R6: peak indices move only after a sweep has been closed
  p_peak_stable_r6: assert property (@(posedge clk) disable iff (!rstN)
    !$past(busy) |-> ($stable(peakEnergy) && $stable(peakDefl) && $stable(peakAnode)));
endmodule

bind peak_window_capture pwc_checker #(
  .NA(NA), .CW(CW), .E_W(E_W), .D_W(D_W), .A_W(A_W)
) u_pwcChecker (.*);

// File: tb/test_peak_window_capture.sv
module test_peak_window_capture;
  localparam int NE = 8, ND = 4, NA = 24, CW = 8;

  logic clk = 1'b0, rstN = 1'b0;
  logic binValid = 1'b0, sweepDone = 1'b0;
  logic [6:0] binEnergy = '0;
  logic [4:0] binDefl = '0, binAnode = '0;
  logic [7:0] binCount = '0;
  logic [6:0] cfgELower, cfgEUpper;
  logic [4:0] cfgDLower, cfgDUpper;
  logic [23:0] cfgMask;
  logic [5:0] cfgEOffset;
  logic [3:0] cfgDOffset;
  logic busy, outValid, outLast;
  logic [7:0] outCount;
  logic [6:0] outEnergy, peakEnergy;
  logic [4:0] outDefl, outAnode, peakDefl, peakAnode;

  peak_window_capture i_peak_window_capture (.*);

  always #4 clk = ~clk;

  int total = 0, bad = 0, cycles = 0;

  // reference model
  int  expC [NE][ND][NA];
  bit  expV [NE][ND][NA];
  int  plant[NE][ND][NA];
  bit  pkF;
  int  pkC, pkE, pkD, pkA;
  int  xE = 0, xD = 0, xA = 0;

  // observed stream
  int obsW[1024];
  bit obsL[1024];
  int obsN = 0;

  always @(negedge clk) begin
    if (outValid && obsN < 1024) begin
      obsW[obsN] = (int'(outEnergy) << 24) | (int'(outDefl) << 16) |
                   (int'(outAnode) << 8) | int'(outCount);
      obsL[obsN] = outLast;
      obsN++;
    end
  end

  task automatic check(bit ok, string req, string what, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000) begin
      bad++;
      total++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cycles, 190000);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  function automatic int minI(int a, int b);
    return (a < b) ? a : b;
  endfunction

  function automatic bit qualifies(int e, int d, int a);
    if (e >= NE || d >= ND || a >= NA) return 0;
    return e >= int'(cfgELower) && e <= minI(int'(cfgEUpper), NE - 1) &&
           d >= int'(cfgDLower) && d <= minI(int'(cfgDUpper), ND - 1) &&
           cfgMask[a];
  endfunction

  function automatic void winCalc(int p, int off, int lo, int hi, output int s, output int t);
    if (2 * off >= hi - lo) begin
      s = lo; t = hi;
    end else begin
      s = p - off;
      if (s < lo) s = lo;
      if (s + 2 * off > hi) s = hi - 2 * off;
      t = s + 2 * off;
    end
  endfunction

  task automatic startSweep();
    foreach (expV[e, d, a]) begin
      expV[e][d][a] = 0;
      expC[e][d][a] = 0;
      plant[e][d][a] = -1;
    end
    pkF = 0;
    obsN = 0;
  endtask

  // drive one bin while collecting and update the model
  task automatic sendBin(int e, int d, int a, int c, bit done);
    binValid = 1'b1; binEnergy = 7'(e); binDefl = 5'(d);
    binAnode = 5'(a); binCount = 8'(c); sweepDone = done;
    if (e < NE && d < ND && a < NA) begin
      expV[e][d][a] = 1;
      expC[e][d][a] = c;
      if (qualifies(e, d, a) && (!pkF || c > pkC)) begin
        pkF = 1; pkC = c; pkE = e; pkD = d; pkA = a;
      end
    end
    @(negedge clk);
    binValid = 1'b0; sweepDone = 1'b0;
  endtask

  task automatic closeSweep(bit alreadyDone);
    if (!alreadyDone) begin
      sweepDone = 1'b1;
      @(negedge clk);
      sweepDone = 1'b0;
    end
    @(negedge clk);
    while (busy) @(negedge clk);
  endtask

  // grid order sweep; planted bins always sent, others with density percent
  task automatic gridSweep(int density, bit doneOnLast);
    int lastE = -1, lastD = -1, lastA = -1;
    int pickE[NE*ND*NA], pickD[NE*ND*NA], pickA[NE*ND*NA], pickC[NE*ND*NA];
    int n = 0;
    for (int e = 0; e < NE; e++)
      for (int d = 0; d < ND; d++)
        for (int a = 0; a < NA; a++) begin
          if (plant[e][d][a] >= 0 || $urandom_range(99, 0) < density) begin
            pickE[n] = e; pickD[n] = d; pickA[n] = a;
            pickC[n] = (plant[e][d][a] >= 0) ? plant[e][d][a] : int'($urandom_range(200, 0));
            n++;
          end
        end
    for (int i = 0; i < n; i++)
      sendBin(pickE[i], pickD[i], pickA[i], pickC[i], doneOnLast && (i == n - 1));
    if (lastE < 0) closeSweep(doneOnLast && n > 0);
  endtask

  task automatic compareSweep(string tag);
    int eS, eT, dS, dT, n, lastIdx, lastCnt, w;
    if (!pkF) begin
      check(obsN == 0, "R7", {tag, " words without peak"}, obsN, 0);
      check({peakEnergy, peakDefl, peakAnode} == {7'(xE), 5'(xD), 5'(xA)}, "R7",
            {tag, " peak kept"}, {peakEnergy, peakDefl, peakAnode}, {7'(xE), 5'(xD), 5'(xA)});
      return;
    end
    winCalc(pkE, int'(cfgEOffset), int'(cfgELower), minI(int'(cfgEUpper), NE - 1), eS, eT);
    winCalc(pkD, int'(cfgDOffset), int'(cfgDLower), minI(int'(cfgDUpper), ND - 1), dS, dT);
    n = 0;
    for (int e = eS; e <= eT; e++)
      for (int d = dS; d <= dT; d++)
        for (int a = 0; a < NA; a++)
          if (cfgMask[a]) begin
            w = (e << 24) | (d << 16) | (a << 8) | (expV[e][d][a] ? expC[e][d][a] : 0);
            if (n < obsN)
              check(obsW[n] == w, "R1 R5", {tag, " word"}, obsW[n], w);
            n++;
          end
    check(obsN == n, tag, "window word count", obsN, n);
    lastCnt = 0; lastIdx = -1;
    for (int i = 0; i < obsN; i++) if (obsL[i]) begin lastCnt++; lastIdx = i; end
    check(lastCnt == 1 && lastIdx == obsN - 1, "R5", {tag, " last flag position"}, lastIdx, obsN - 1);
    check({peakEnergy, peakDefl, peakAnode} == {7'(pkE), 5'(pkD), 5'(pkA)}, "R2 R6",
          {tag, " exported peak"}, {peakEnergy, peakDefl, peakAnode}, {7'(pkE), 5'(pkD), 5'(pkA)});
    xE = pkE; xD = pkD; xA = pkA;
  endtask

  task automatic setCfg(int el, int eu, int dl, int du, int msk, int eo, int dO);
    cfgELower = 7'(el); cfgEUpper = 7'(eu); cfgDLower = 5'(dl); cfgDUpper = 5'(du);
    cfgMask = 24'(msk); cfgEOffset = 6'(eo); cfgDOffset = 4'(dO);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    setCfg(0, 127, 0, 31, 24'hFFFFFF, 1, 1);
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R9 reset state
    check(!busy && !outValid && !outLast, "R9", "idle after reset", {busy, outValid, outLast}, 0);
    check({peakEnergy, peakDefl, peakAnode} == '0, "R9", "peak after reset",
          {peakEnergy, peakDefl, peakAnode}, 0);

    // R3 centred window
    startSweep();
    plant[4][2][5] = 250;
    gridSweep(100, 0);
    compareSweep("R3");

    // R2 tie: first in arrival order wins
    setCfg(0, 127, 0, 31, 24'hFFFFFF, 1, 0);
    startSweep();
    plant[2][1][3] = 240; plant[5][2][0] = 240;
    gridSweep(60, 0);
    check(pkE == 2 && pkD == 1 && pkA == 3, "R2", "model tie pick", pkE, 2);
    compareSweep("R2");

    // R4 clamp at lower energy bound and at effective upper bound
    setCfg(0, 127, 0, 31, 24'h0000FF, 2, 1);
    startSweep();
    plant[0][0][1] = 251;
    gridSweep(50, 0);
    compareSweep("R4");
    setCfg(1, 100, 1, 31, 24'h00F00F, 2, 1);
    startSweep();
    plant[7][3][2] = 252;
    gridSweep(50, 0);
    compareSweep("R4");

    // R4 window wider than range covers the whole range
    setCfg(2, 6, 0, 2, 24'h000F00, 10, 5);
    startSweep();
    plant[4][1][9] = 253;
    gridSweep(40, 0);
    compareSweep("R4");

    // R5 sparse mask skipping
    setCfg(0, 7, 0, 3, 24'h800A05, 1, 1);
    startSweep();
    plant[3][1][23] = 249;
    gridSweep(70, 0);
    compareSweep("R5");

    // R7 nothing qualifies: mask empty
    setCfg(0, 7, 0, 3, 24'h000000, 1, 1);
    startSweep();
    gridSweep(30, 0);
    compareSweep("R7");
    // R7 nothing qualifies: energy bounds crossed
    setCfg(6, 3, 0, 3, 24'hFFFFFF, 1, 1);
    startSweep();
    gridSweep(30, 0);
    compareSweep("R7");

    // R10 out-of-buffer bins ignored; R8 bin with sweepDone counted
    setCfg(0, 127, 0, 31, 24'hFFFFFF, 1, 1);
    startSweep();
    sendBin(NE, 0, 0, 255, 0);
    sendBin(0, ND, 0, 255, 0);
    sendBin(0, 0, NA, 255, 0);
    sendBin(1, 1, 1, 100, 0);
    sendBin(6, 2, 7, 200, 1);
    closeSweep(1);
    check(pkE == 6, "R10", "model ignores out-of-range", pkE, 6);
    compareSweep("R10 R8");

    // R8 inputs ignored while busy
    startSweep();
    sendBin(3, 1, 4, 90, 1);
    sendBin(5, 3, 20, 255, 1);
    binValid = 1'b1; binEnergy = 7'd2; binDefl = 5'd2; binAnode = 5'd2;
    binCount = 8'd254; sweepDone = 1'b1;
    @(negedge clk);
    binValid = 1'b0; sweepDone = 1'b0;
    expV[5][3][20] = 0; expC[5][3][20] = 0; pkF = 1; pkC = 90; pkE = 3; pkD = 1; pkA = 4;
    closeSweep(1);
    compareSweep("R8");
    check(!busy, "R8", "no extra sweep from done while busy", busy, 0);
    startSweep();
    sendBin(2, 1, 0, 50, 1);
    closeSweep(1);
    compareSweep("R8 R1");

    // random sweeps
    for (int k = 0; k < 8; k++) begin
      int el = $urandom_range(4, 0), eu = $urandom_range(20, 3);
      int dl = $urandom_range(2, 0), du = $urandom_range(8, 1);
      setCfg(el, eu, dl, du, int'($urandom_range(32'hFFFFFF, 1)),
             $urandom_range(4, 0), $urandom_range(3, 0));
      startSweep();
      gridSweep($urandom_range(90, 10), k[0]);
      compareSweep("R1");
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule